// File: doc/BRIEF.md
# Time-Multiplexed Tower Dispatcher

This block takes a complete set of tower energy words, delivered once per bunch-crossing period, and deals it out to a small bank of parallel algorithm cores across the fast processing cycles of that period. The processing clock runs at five times the crossing rate. Eight cores each handle one core tower per fast cycle, so five cycles cover all forty core towers. A one-cycle load pulse, aligned with the slow clock edge, marks the fast edge on which a new set of sixty words is present on the input bus.

The sixty towers form a grid of 5 rows (phi) by 12 columns (eta), with tower index `t = row*12 + col`. Columns 2 to 9 hold the forty core towers. Core tower number `8*row + (col-2)` sits at that position. Columns 0, 1, 10 and 11 are environment only. In phase k the block presents row k. Core i receives a five-word eta window made of columns i to i+4 of that row, and tap 2 is its own core tower. When the block sits at a detector edge, one or both outer columns are not supplied. Two configuration pins then replace column 0 or column 11 with zero words as the set is captured.

The cores are fixed-latency pipelines and cannot stall, so the core-side stream has a valid strobe and no ready. A valid set cannot be back-pressured. A load that comes while a set is still being dispatched is not accepted. Each valid cycle carries its phase index so that downstream logic can tag its results.

Top module: `tower_dispatch`

## Requirements
- R1: After reset, and whenever no set is being dispatched, `out_valid` is 0, `out_phase` is 0 and every word of `core_win` is zero.
- R2: A load is accepted when the block is idle or is showing its last phase (`out_phase` = 4). In the next cycle `out_valid` is 1 and `out_phase` is 0.
- R3: While valid, `out_phase` rises by one each cycle, from 0 to 4.
- R4: Each accepted load gives exactly 5 valid cycles. A load accepted during phase 4 makes phase 0 of the new set follow at once, with no gap in `out_valid`.
- R5: A load during phases 0 to 3 is ignored. The phase sequence continues and the dispatched words still come from the earlier set.
- R6: In phase k, core i tap j (word `(i*5+j)` of `core_win`, W bits each) carries tower `k*12 + i + j` of the captured set.
- R7: If `border_lo` is 1 on the accepted load, every column 0 word of that set is dispatched as zero, even if `border_lo` later drops.
- R8: If `border_hi` is 1 on the accepted load, every column 11 word of that set is dispatched as zero.
- R9: If a border pin is 0 on the accepted load, the matching edge column passes through unchanged as environment.
- R10: Changes on `towers_in` between accepted loads have no effect on `core_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock (5x crossing rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle marker that a new tower set is present |
| border_lo | input | 1 | Zero the low-eta outer column of the set being loaded |
| border_hi | input | 1 | Zero the high-eta outer column of the set being loaded |
| towers_in | input | 60*W | Tower words, tower t at bits `[t*W +: W]` |
| out_valid | output | 1 | Core windows carry live data this cycle |
| out_phase | output | 3 | Phase index 0..4 of the dispatched row |
| core_win | output | 8*5*W | Eta windows for the eight cores, core i tap j at `[(i*5+j)*W +: W]` |

## Verification
Two events can fall in the same cycle: the closing phase of one set and the load of the next. The bench provokes this by raising `load` while phase 4 is on the outputs. It then requires phase 0 of the new set in the very next cycle, with `out_valid` never dropping and every window word drawn from the new pattern. A second collision is a load during an early phase together with a change on the tower bus. That case is judged by checking that the remaining phases still show the first set's words and that `out_valid` falls after phase 4.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
  localparam int DEF_WORD_W  = 16;
  localparam int DEF_CORES   = 8;
  localparam int DEF_PHASES  = 5;
  localparam int DEF_HALFWIN = 2;

  // Flat grid index of a tower from its row and column.
  function automatic int grid_idx(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction
endpackage

// File: rtl/tdisp_seq.sv
module tdisp_seq #(
  parameter int N_PHASES = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  output logic                        accept,
  output logic                        valid_q,
  output logic [$clog2(N_PHASES)-1:0] phase_q
);
  localparam int PW = $clog2(N_PHASES);
  localparam logic [PW-1:0] LAST = PW'(N_PHASES - 1);

  logic at_last;

  assign at_last = (phase_q == LAST);
  // Take a new set only when nothing is in flight or the last row is showing.
  assign accept  = load && (!valid_q || at_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phase_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      phase_q <= '0;
    end else if (valid_q) begin
      if (at_last) begin
        valid_q <= 1'b0;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/tdisp_capture.sv
module tdisp_capture #(
  parameter int W      = 16,
  parameter int N_ROWS = 5,
  parameter int N_COLS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       border_lo,
  input  logic                       border_hi,
  input  logic [N_ROWS*N_COLS*W-1:0] towers_in,
  output logic [N_ROWS*N_COLS*W-1:0] cap_q
);
  import tdisp_pkg::*;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
      localparam int IDX = grid_idx(r, c, N_COLS);
      logic kill;
      // Only the two outer columns can be replaced by zero words.
      if (c == 0) begin : g_lo
        assign kill = border_lo;
      end else if (c == N_COLS - 1) begin : g_hi
        assign kill = border_hi;
      end else begin : g_mid
        assign kill = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cap_q[IDX*W +: W] <= '0;
        end else if (accept) begin
          cap_q[IDX*W +: W] <= kill ? '0 : towers_in[IDX*W +: W];
        end
      end
    end
  end
endmodule

// File: rtl/tdisp_window_mux.sv
module tdisp_window_mux #(
  parameter int W       = 16,
  parameter int N_CORES = 8,
  parameter int N_ROWS  = 5,
  parameter int WIN     = 5,
  parameter int N_COLS  = 12
) (
  input  logic [N_ROWS*N_COLS*W-1:0]  cap_q,
  input  logic                        valid,
  input  logic [$clog2(N_ROWS)-1:0]   phase,
  output logic [N_CORES*WIN*W-1:0]    core_win
);
  import tdisp_pkg::*;
  localparam int PW = $clog2(N_ROWS);

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    for (genvar j = 0; j < WIN; j++) begin : g_tap
      logic [W-1:0] word;
      // Pick this tap's column from the row named by the phase.
      always_comb begin
        word = '0;
        for (int r = 0; r < N_ROWS; r++) begin
          if (phase == PW'(r)) begin
            word = cap_q[grid_idx(r, i + j, N_COLS)*W +: W];
          end
        end
      end
      assign core_win[(i*WIN + j)*W +: W] = valid ? word : '0;
    end
  end
endmodule

// File: rtl/tower_dispatch.sv
module tower_dispatch #(
  parameter int W        = tdisp_pkg::DEF_WORD_W,
  parameter int N_CORES  = tdisp_pkg::DEF_CORES,
  parameter int N_PHASES = tdisp_pkg::DEF_PHASES,
  parameter int HALF_WIN = tdisp_pkg::DEF_HALFWIN
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                load,
  input  logic                                                border_lo,
  input  logic                                                border_hi,
  input  logic [N_PHASES*(N_CORES+2*HALF_WIN)*W-1:0]          towers_in,
  output logic                                                out_valid,
  output logic [$clog2(N_PHASES)-1:0]                         out_phase,
  output logic [N_CORES*(2*HALF_WIN+1)*W-1:0]                 core_win
);
  localparam int WIN    = 2 * HALF_WIN + 1;
  localparam int N_COLS = N_CORES + 2 * HALF_WIN;
  localparam int N_TOW  = N_PHASES * N_COLS;

  logic             accept;
  logic [N_TOW*W-1:0] cap_q;

  tdisp_seq #(.N_PHASES(N_PHASES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .accept  (accept),
    .valid_q (out_valid),
    .phase_q (out_phase)
  );

  tdisp_capture #(.W(W), .N_ROWS(N_PHASES), .N_COLS(N_COLS)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .border_lo (border_lo),
    .border_hi (border_hi),
    .towers_in (towers_in),
    .cap_q     (cap_q)
  );

  tdisp_window_mux #(
    .W(W), .N_CORES(N_CORES), .N_ROWS(N_PHASES), .WIN(WIN), .N_COLS(N_COLS)
  ) u_mux (
    .cap_q    (cap_q),
    .valid    (out_valid),
    .phase    (out_phase),
    .core_win (core_win)
  );
endmodule

// File: rtl/tower_dispatch_chk.sv
module tower_dispatch_chk #(
  parameter int W        = 16,
  parameter int N_CORES  = 8,
  parameter int N_PHASES = 5,
  parameter int HALF_WIN = 2
) (
  input logic                                       clk,
  input logic                                       rst_n,
  input logic                                       load,
  input logic                                       border_lo,
  input logic                                       border_hi,
  input logic                                       out_valid,
  input logic [$clog2(N_PHASES)-1:0]                out_phase,
  input logic [N_CORES*(2*HALF_WIN+1)*W-1:0]        core_win,
  input logic [N_PHASES*(N_CORES+2*HALF_WIN)*W-1:0] cap
);
  localparam int PW  = $clog2(N_PHASES);
  localparam int WIN = 2 * HALF_WIN + 1;
  localparam logic [PW-1:0] LAST = PW'(N_PHASES - 1);
  localparam int HI_OFS = ((N_CORES - 1) * WIN + WIN - 1) * W;

  logic take;
  assign take = load && (!out_valid || out_phase == LAST);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_phase == '0 && core_win == '0));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_phase == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != LAST) |=>
      (out_valid && out_phase == $past(out_phase) + PW'(1)));

  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase == LAST && !load) |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase != LAST) |=> $stable(cap));

  a_r7_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take && border_lo) |=> core_win[0 +: W] == '0);

  a_r8_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take && border_hi) |=> core_win[HI_OFS +: W] == '0);
endmodule

bind tower_dispatch tower_dispatch_chk #(
  .W(W), .N_CORES(N_CORES), .N_PHASES(N_PHASES), .HALF_WIN(HALF_WIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .border_lo (border_lo),
  .border_hi (border_hi),
  .out_valid (out_valid),
  .out_phase (out_phase),
  .core_win  (core_win),
  .cap       (cap_q)
);

// File: tb/tb_tower_dispatch.sv
module tb_tower_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 16;
  localparam int NC     = 8;
  localparam int NP     = 5;
  localparam int WIN    = 5;
  localparam int NCOL   = 12;
  localparam int NT     = NP * NCOL;
  localparam logic [7:0] JUNK = 8'hEE;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic              border_lo = 1'b0;
  logic              border_hi = 1'b0;
  logic [NT*W-1:0]   towers_in = '0;
  logic              out_valid;
  logic [2:0]        out_phase;
  logic [NC*WIN*W-1:0] core_win;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tower_dispatch dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .border_lo(border_lo), .border_hi(border_hi),
    .towers_in(towers_in), .out_valid(out_valid),
    .out_phase(out_phase), .core_win(core_win)
  );

  function automatic logic [W-1:0] pat(input logic [7:0] seed, input int t);
    return {seed, 8'(t)};
  endfunction

  function automatic logic [NT*W-1:0] make_set(input logic [7:0] seed);
    logic [NT*W-1:0] v;
    for (int t = 0; t < NT; t++) v[t*W +: W] = pat(seed, t);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // R1: idle outputs quiet.
  task automatic check_idle(input string req);
    check(req, {31'd0, out_valid}, 32'd0);
    check(req, {29'd0, out_phase}, 32'd0);
    n_chk++;
    if (core_win !== '0) begin
      n_bad++;
      $display("FAIL %s: actual core_win nonzero expected zero", req);
    end
  endtask

  // Present a set with load high for one cycle; return at the negedge showing phase 0.
  task automatic start_load(input logic [7:0] seed, input logic bl, input logic bh);
    @(negedge clk);
    load = 1'b1; towers_in = make_set(seed); border_lo = bl; border_hi = bh;
    @(negedge clk);
    load = 1'b0; towers_in = make_set(JUNK); border_lo = 1'b0; border_hi = 1'b0;
  endtask

  // Check all phases of one set (R3, R6, R7, R8, R9). Optionally raise load at phase inj.
  task automatic run_phases(input logic [7:0] seed, input logic bl, input logic bh,
                            input int inj, input logic [7:0] iseed,
                            input logic ibl, input logic ibh);
    for (int k = 0; k < NP; k++) begin
      if (k > 0) begin
        @(negedge clk);
        load = 1'b0; towers_in = make_set(JUNK); border_lo = 1'b0; border_hi = 1'b0;
      end
      check("R3 valid", {31'd0, out_valid}, 32'd1);
      check("R3 phase", {29'd0, out_phase}, k);
      for (int i = 0; i < NC; i++) begin
        for (int j = 0; j < WIN; j++) begin
          int col = i + j;
          logic [W-1:0] e;
          e = pat(seed, k*NCOL + col);
          if (col == 0 && bl) e = '0;          // R7
          if (col == NCOL-1 && bh) e = '0;     // R8
          check((col == 0 || col == NCOL-1) ? "R7/R8/R9 edge" : "R6 window",
                {16'd0, core_win[(i*WIN+j)*W +: W]}, {16'd0, e});
        end
      end
      if (k == inj) begin
        load = 1'b1; towers_in = make_set(iseed); border_lo = ibl; border_hi = ibh;
      end
    end
    @(negedge clk);
    load = 1'b0; towers_in = make_set(JUNK); border_lo = 1'b0; border_hi = 1'b0;
    if (inj == NP-1) begin
      check("R4 no gap valid", {31'd0, out_valid}, 32'd1);
      check("R2 restart phase", {29'd0, out_phase}, 32'd0);
    end else begin
      check_idle("R4 valid ends after 5");
    end
  endtask

  task automatic t_reset();
    check_idle("R1 reset");
  endtask

  task automatic t_basic();
    start_load(8'h11, 1'b0, 1'b0);      // R2
    run_phases(8'h11, 1'b0, 1'b0, -1, 8'h0, 1'b0, 1'b0);   // R9, R10
  endtask

  task automatic t_back_to_back();
    start_load(8'h22, 1'b0, 1'b0);
    run_phases(8'h22, 1'b0, 1'b0, NP-1, 8'h33, 1'b1, 1'b0); // R4
    run_phases(8'h33, 1'b1, 1'b0, -1, 8'h0, 1'b0, 1'b0);
  endtask

  task automatic t_early_load();
    start_load(8'h44, 1'b0, 1'b1);
    run_phases(8'h44, 1'b0, 1'b1, 1, 8'h55, 1'b1, 1'b1);   // R5 ignored
    repeat (3) @(negedge clk);
    check_idle("R5 ignored load never restarts");
  endtask

  task automatic t_both_borders();
    start_load(8'h66, 1'b1, 1'b1);
    run_phases(8'h66, 1'b1, 1'b1, -1, 8'h0, 1'b0, 1'b0);   // R7, R8
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_back_to_back();
    t_early_load();
    t_both_borders();
    repeat (2) @(negedge clk);
    finish();
  end
endmodule